// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block sits between the pulse-width modulator and the gate drivers of a synchronous step-down stage. It turns a per-cycle PWM request into two drive enables, one for the upper (control) switch and one for the lower (rectifier) switch. It keeps the two from ever conducting together by inserting a fixed number of idle clocks, set by a parameter, every time conduction passes from one switch to the other.

A static mode input selects between two rectifier policies. In diode-emulation (source-only) mode the rectifier is released as soon as the inductor current reaches zero, so current never reverses. In two-quadrant (source/sink) mode the rectifier stays on until the next cycle start, whatever the current. The fault, overvoltage and early-termination inputs override the normal sequence in ways that also depend on the mode.

Top module: `sync_gate_ctrl`

## Requirements
- R1: `hs_on` and `ls_on` are never high in the same cycle.
- R2: When conduction passes from one switch to the other through the normal sequence, both enables stay low for exactly `DEAD_CLKS` clock edges before the other enable rises: `hs_on` rises `DEAD_CLKS` edges after the cycle start that turned `ls_on` off, and `ls_on` rises `DEAD_CLKS` edges after `pwm_req` low turned `hs_on` off.
- R3: With `sink_en` = 0 (source-only), an asserted `zc_det` while `ls_on` is high turns `ls_on` off at the next edge; a cycle start with `pwm_req` high that comes first also turns it off.
- R4: With `sink_en` = 1 (source/sink), `zc_det` has no effect; `ls_on` stays high until a cycle start.
- R5: `hs_on` goes low in the same cycle that `fault` is asserted and stays low while `fault` is high, even across cycle starts.
- R6: With `sink_en` = 0, an asserted `fault` forces `ls_on` low from the next edge on and keeps it low.
- R7: With `sink_en` = 1, an asserted `fault` brings `ls_on` high after the dead time and holds it high while `fault` lasts, ignoring cycle starts.
- R8: With `sink_en` = 1 and `ovp` high, a cycle start with `pwm_req` low leaves `ls_on` high; a cycle start with `pwm_req` high still turns it off and starts a new high-side pulse.
- R9: An asserted `cut_req` drops `hs_on` in the same cycle; `ls_on` rises `DEAD_CLKS` edges after the next clock edge.
- R10: Without `ovp`, a cycle start with `pwm_req` low turns `ls_on` off and leaves both enables low.
- R11: While `rst_n` is low both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse marking the start of a switching cycle |
| pwm_req | input | 1 | High while the modulator asks for upper-switch conduction |
| cut_req | input | 1 | Early termination of the current upper-switch pulse |
| zc_det | input | 1 | Inductor current has reached zero |
| fault | input | 1 | Declared fault; upper switch held off |
| ovp | input | 1 | Output overvoltage |
| sink_en | input | 1 | Static mode: 0 source-only, 1 source/sink |
| hs_on | output | 1 | Upper-switch drive enable |
| ls_on | output | 1 | Rectifier drive enable |

## Verification
A scoreboard records every change of the enable pair together with the number of edges since the previous change, so a normal PWM drop, a cycle-start handover, an early termination and a fault entry are told apart by their distinct gaps (dead time versus dead time plus one). The zero-current input is pulsed in both modes while the rectifier conducts, which separates the two turn-off policies, and zero-duty cycle starts are applied with and without overvoltage to separate the hold and release cases. Faults are raised both while the upper switch is on and while the rectifier is on, in each mode, with cycle starts applied during the fault to show they are ignored.

// File: rtl/sync_gate_ctrl.sv
module sync_gate_ctrl #(
  parameter int DEAD_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic pwm_req,
  input  logic cut_req,
  input  logic zc_det,
  input  logic fault,
  input  logic ovp,
  input  logic sink_en,
  output logic hs_on,
  output logic ls_on
);
  localparam int CW = (DEAD_CLKS < 2) ? 1 : $clog2(DEAD_CLKS);
  localparam logic [CW-1:0] CLOAD = CW'(DEAD_CLKS - 1);

  typedef enum logic [2:0] {S_OFF, S_DLH, S_HS, S_DHL, S_LS} st_t;
  st_t st, nx;
  logic [CW-1:0] cnt;
  logic dead_done;

  assign dead_done = (cnt == '0);

  always_comb begin
    nx = st;
    case (st)
      S_OFF:
        if (fault) nx = sink_en ? S_DHL : S_OFF;
        else if (cyc_start && pwm_req) nx = S_DLH;
      S_DLH:
        if (fault) nx = S_DHL;
        else if (dead_done) nx = pwm_req ? S_HS : S_DHL;
      S_HS:
        if (fault || cut_req || !pwm_req) nx = S_DHL;
      S_DHL:
        if (dead_done) nx = (fault && !sink_en) ? S_OFF : S_LS;
      S_LS:
        if (fault) nx = sink_en ? S_LS : S_OFF;
        else if (cyc_start && pwm_req) nx = S_DLH;
        else if (cyc_start && !(sink_en && ovp)) nx = S_OFF;
        else if (!sink_en && zc_det) nx = S_OFF;
      default: nx = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      st <= nx;
      if (nx != st) cnt <= CLOAD;
      else if (!dead_done) cnt <= cnt - 1'b1;
    end
  end

  assign hs_on = (st == S_HS) && !fault && !cut_req;
  assign ls_on = (st == S_LS);

  p_never_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));
  p_ls_after_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_on) |=> !ls_on);
  p_hs_after_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_on) |=> !hs_on);
  p_zc_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sink_en && zc_det && ls_on && !fault) |=> !ls_on);
  p_fault_hs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !hs_on);
  p_fault_src_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sink_en && fault) |=> !ls_on);
  p_fault_sink_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_en && fault && ls_on) |=> ls_on);
  p_ovp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_en && ovp && ls_on && cyc_start && !pwm_req && !fault) |=> ls_on);
  p_cut_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cut_req |-> !hs_on);
endmodule

// File: tb/sim_sync_gate_ctrl.sv
`timescale 1ns/1ps
module sim_sync_gate_ctrl;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n, cyc_start, pwm_req, cut_req, zc_det, fault, ovp, sink_en;
  logic hs_on, ls_on;

  int vectors = 0;
  int errors = 0;
  int ncnt = 0;
  int last_edge = 0;
  logic ph = 1'b0, pl = 1'b0;
  bit overlap_seen = 0;

  int    qh[$];
  int    ql[$];
  int    qg[$];
  string qt[$];

  always #5 clk = ~clk;

  sync_gate_ctrl #(.DEAD_CLKS(D)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .pwm_req(pwm_req),
    .cut_req(cut_req), .zc_det(zc_det), .fault(fault), .ovp(ovp),
    .sink_en(sink_en), .hs_on(hs_on), .ls_on(ls_on));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_edge(input int h, input int l, input int gap, input string tag);
    qh.push_back(h); ql.push_back(l); qg.push_back(gap); qt.push_back(tag);
  endtask

  task automatic chk(input logic h, input logic l, input string tag);
    @(negedge clk);
    vectors++;
    if (hs_on !== h || ls_on !== l) begin
      errors++;
      $display("FAIL %s: hs/ls actual %b%b expected %b%b", tag, hs_on, ls_on, h, l);
    end
  endtask

  task automatic pulse_start(input logic p);
    pwm_req = p; cyc_start = 1'b1;
    step(1);
    cyc_start = 1'b0;
  endtask

  // monitor: pops one expected transition per observed change of the pair
  always @(negedge clk) begin
    if (rst_n) begin
      ncnt++;
      if (hs_on && ls_on) overlap_seen = 1;
      if (hs_on !== ph || ls_on !== pl) begin
        int gap;
        gap = ncnt - last_edge;
        vectors++;
        if (qh.size() == 0) begin
          errors++;
          $display("FAIL unexpected edge: actual %b%b expected none", hs_on, ls_on);
        end else begin
          int eh, el, eg;
          string et;
          eh = qh.pop_front(); el = ql.pop_front();
          eg = qg.pop_front(); et = qt.pop_front();
          if (hs_on !== eh[0] || ls_on !== el[0] || (eg >= 0 && gap != eg)) begin
            errors++;
            $display("FAIL %s: actual %b%b gap %0d expected %0d%0d gap %0d",
                     et, hs_on, ls_on, gap, eh, el, eg);
          end
        end
        last_edge = ncnt;
        ph = hs_on; pl = ls_on;
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cyc_start = 0; pwm_req = 0; cut_req = 0;
    zc_det = 0; fault = 0; ovp = 0; sink_en = 1;
    step(3);
    chk(0, 0, "R11 reset");
    rst_n = 1;
    step(2);

    // source/sink: normal cycle
    expect_edge(1, 0, -1, "R2 first hs");
    pulse_start(1); step(D + 2);
    chk(1, 0, "R2 hs on");
    expect_edge(0, 0, -1, "R2 hs off");
    expect_edge(0, 1, D, "R2 hs->ls dead");
    pwm_req = 0; step(D + 2);
    chk(0, 1, "R2 ls on");

    // zero current ignored in source/sink
    zc_det = 1; step(3);
    chk(0, 1, "R4 zc ignored");
    zc_det = 0;
    expect_edge(0, 0, -1, "R4 ls off at start");
    expect_edge(1, 0, D, "R2 ls->hs dead");
    pulse_start(1); step(D + 2);

    // early termination
    expect_edge(0, 0, -1, "R9 cut");
    expect_edge(0, 1, D + 1, "R9 ls after cut");
    cut_req = 1;
    chk(0, 0, "R9 immediate drop");
    step(1); cut_req = 0;
    step(D + 2);
    chk(0, 1, "R9 ls on");
    pwm_req = 0;

    // overvoltage hold
    ovp = 1;
    pulse_start(0); step(2);
    chk(0, 1, "R8 zero duty hold");
    expect_edge(0, 0, -1, "R8 ls off with duty");
    expect_edge(1, 0, D, "R8 hs after dead");
    pulse_start(1); step(D + 2);
    ovp = 0;
    expect_edge(0, 0, -1, "R2 hs off");
    expect_edge(0, 1, D, "R2 hs->ls dead");
    pwm_req = 0; step(D + 2);

    // zero duty without overvoltage
    expect_edge(0, 0, -1, "R10 zero duty release");
    pulse_start(0); step(2);
    chk(0, 0, "R10 both off");

    // fault in source/sink while hs on
    expect_edge(1, 0, -1, "R2 hs on");
    pulse_start(1); step(D + 2);
    expect_edge(0, 0, -1, "R5 fault drop");
    expect_edge(0, 1, D + 1, "R7 ls on in fault");
    fault = 1;
    chk(0, 0, "R5 hs low at once");
    step(D + 3);
    chk(0, 1, "R7 ls held");
    pulse_start(1); step(D + 2);
    chk(0, 1, "R7 start ignored in fault");
    fault = 0;
    expect_edge(0, 0, -1, "R2 ls off");
    expect_edge(1, 0, D, "R2 ls->hs dead");
    pulse_start(1); step(D + 2);
    expect_edge(0, 0, -1, "R2 hs off");
    expect_edge(0, 1, D, "R2 hs->ls dead");
    pwm_req = 0; step(D + 2);

    // source-only mode
    sink_en = 0;
    expect_edge(0, 0, -1, "R3 zc release");
    zc_det = 1; step(1); zc_det = 0;
    chk(0, 0, "R3 ls off on zc");
    step(1);
    expect_edge(1, 0, -1, "R2 hs on");
    pulse_start(1); step(D + 2);
    expect_edge(0, 0, -1, "R2 hs off");
    expect_edge(0, 1, D, "R2 hs->ls dead src");
    pwm_req = 0; step(D + 2);
    expect_edge(0, 0, -1, "R3 start before zc");
    expect_edge(1, 0, D, "R2 ls->hs dead src");
    pulse_start(1); step(D + 2);

    // fault in source-only while hs on
    expect_edge(0, 0, -1, "R5 fault drop src");
    fault = 1;
    chk(0, 0, "R5 hs low at once src");
    step(D + 4);
    chk(0, 0, "R6 ls stays off");
    pulse_start(1); step(D + 2);
    chk(0, 0, "R5 start ignored in fault");
    fault = 0; pwm_req = 0; step(2);

    // fault in source-only while ls on
    expect_edge(1, 0, -1, "R2 hs on");
    pulse_start(1); step(D + 2);
    expect_edge(0, 0, -1, "R2 hs off");
    expect_edge(0, 1, D, "R2 hs->ls dead src");
    pwm_req = 0; step(D + 2);
    expect_edge(0, 0, -1, "R6 fault ls off");
    fault = 1; step(1);
    chk(0, 0, "R6 ls off next edge");
    step(2);
    fault = 0;
    step(5);

    vectors++;
    if (qh.size() != 0) begin
      errors++;
      $display("FAIL pending edges: actual %0d expected 0", qh.size());
    end
    vectors++;
    if (overlap_seen) begin
      errors++;
      $display("FAIL R1 overlap: actual 1 expected 0");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule